// File: doc/BRIEF.md
# Configurable Registered Command Buffer

This block is a single clocked register stage placed between a memory controller and the devices on a memory module. It captures address and command bits on the rising clock edge and presents them one cycle later. A two-bit strap picks its shape. In the wide shape it is a 25-lane register with one copy of each output. In the duplicated shape it is a 14-lane register, and each lane drives an A copy and a B copy, so one input can load two banks of devices.

Two active-low select inputs gate the ordinary data lanes: the chip select and the select-register enable. While both are high at a capturing edge, the data lanes keep their previous values. The chip-select outputs always register. The lanes that carry clock-enable and on-die termination also always register. Which lanes carry those two signals depends on the strap. Tying the select-register enable low makes every lane register on every edge. An asynchronous active-low reset clears every flop and forces every output low. The straps are static and change only while reset is held.

Top module: `cmd_regbuf`

## Requirements
- R1: While `rst_n` is low, every output is 0. This holds immediately when reset falls, with no clock edge needed. After `rst_n` rises, the outputs stay 0 until the first rising clock edge.
- R2: With `cfg_dup`=0 and at least one select input low, each rising edge loads all 25 bits of `d_in` into `q_a`, in the same bit positions.
- R3: With `cfg_dup`=0, `q_b` and `q_cs_n_b` are constant 0.
- R4: With `cfg_dup`=1, an ungated edge loads `d_in[13:0]` into both `q_a[13:0]` and `q_b`. In this mode `q_a[24:14]` is 0, and `q_cs_n_a` equals `q_cs_n_b`.
- R5: When `cs_n`=1 and `csr_n`=1 at an edge, every data lane other than the clock-enable and termination lanes keeps its value.
- R6: When exactly one of `cs_n` and `csr_n` is low, the edge updates every lane. This includes `cs_n`=1 with `csr_n`=0.
- R7: `q_cs_n_a` (and `q_cs_n_b` in duplicated mode) takes the value `cs_n` had at every rising edge, whatever the gating.
- R8: In wide mode, and in duplicated mode with `cfg_layout_b`=0, lane 0 (clock enable) and lane 3 (termination) update even when gated.
- R9: In duplicated mode with `cfg_layout_b`=1, the ungated lanes are lane 10 (termination) and lane 13 (clock enable). In this layout lanes 0 and 3 are gated like any other data lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_dup | input | 1 | Strap: 0 gives the 25-lane single-copy shape, 1 gives the 14-lane duplicated shape |
| cfg_layout_b | input | 1 | Strap in duplicated mode: 0 gives layout A, 1 gives layout B |
| cs_n | input | 1 | Chip select, active low |
| csr_n | input | 1 | Select-register enable, active low |
| d_in | input | 25 | Address and command lanes |
| q_a | output | 25 | Registered lanes, A copy |
| q_b | output | 14 | Registered lanes, B copy (0 in wide mode) |
| q_cs_n_a | output | 1 | Registered chip select, A copy |
| q_cs_n_b | output | 1 | Registered chip select, B copy (0 in wide mode) |

## Verification
The bench targets the gated edges. A design that froze every lane would lose the clock-enable and termination updates. A design that froze none would let the data lanes follow the input. The bench also targets the edge where `cs_n` is high and `csr_n` is low, which a design that gated on `cs_n` alone would wrongly hold. The layout B run checks that the ungated lanes move to 10 and 13, and that lanes 0 and 3 become gated. A design that kept the layout A positions would show the wrong bits there. Reset is dropped between clock edges to catch a synchronous reset. The outputs are also sampled after reset release and before any edge, to catch outputs that load early.

// File: rtl/cmdreg_pkg.sv
// Package: shared lane counts and control-lane positions for the command buffer.
// Assumes lane numbering from 0 and that the straps are static during operation.
package cmdreg_pkg;
    localparam int WIDE_LANES   = 25;
    localparam int NARROW_LANES = 14;
    localparam int CKE_LANE_A   = 0;
    localparam int ODT_LANE_A   = 3;
    localparam int ODT_LANE_B   = 10;
    localparam int CKE_LANE_B   = 13;
endpackage

// File: rtl/cmdreg_lane_ctrl.sv
// Lane control: decides, per lane, whether the next edge loads it.
// Assumes cfg_dup/cfg_layout_b are static; control lanes ignore the select gating.
module cmdreg_lane_ctrl #(
    parameter int W     = cmdreg_pkg::WIDE_LANES,
    parameter int CKE_A = cmdreg_pkg::CKE_LANE_A,
    parameter int ODT_A = cmdreg_pkg::ODT_LANE_A,
    parameter int ODT_B = cmdreg_pkg::ODT_LANE_B,
    parameter int CKE_B = cmdreg_pkg::CKE_LANE_B
) (
    input  logic         cs_n,
    input  logic         csr_n,
    input  logic         cfg_dup,
    input  logic         cfg_layout_b,
    output logic [W-1:0] upd_en
);
    logic hold;
    logic use_b;

    // Gate only when both selects are inactive.
    always_comb hold = cs_n & csr_n;

    // Layout B positions apply only in duplicated mode.
    always_comb use_b = cfg_dup & cfg_layout_b;

    for (genvar i = 0; i < W; i++) begin : g_lane
        localparam bit IS_A = (i == CKE_A) || (i == ODT_A);
        localparam bit IS_B = (i == CKE_B) || (i == ODT_B);
        // Per-lane enable: free-running control lanes, gated data lanes.
        always_comb begin
            if (use_b)
                upd_en[i] = ~hold | IS_B;
            else
                upd_en[i] = ~hold | IS_A;
        end
    end
endmodule

// File: rtl/cmdreg_bank.sv
// Register bank: one enabled flop per lane with asynchronous active-low clear.
// Assumes upd_en is settled before the rising edge.
module cmdreg_bank #(
    parameter int W = cmdreg_pkg::WIDE_LANES
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] upd_en,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_flop
        // Load the lane when enabled, otherwise hold; clear on reset.
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                q[i] <= 1'b0;
            else if (upd_en[i])
                q[i] <= d[i];
        end

        // R5
        hold_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !upd_en[i] |=> $stable(q[i]));

        // R2
        load_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
            upd_en[i] |=> q[i] == $past(d[i]));
    end
endmodule

// File: rtl/cmdreg_fanout.sv
// Output fan-out: maps stored lanes onto the A and B copies per strap.
// Assumes the wide shape drives B copies to 0 and the duplicated shape zeroes the upper A lanes.
module cmdreg_fanout #(
    parameter int WIDE   = cmdreg_pkg::WIDE_LANES,
    parameter int NARROW = cmdreg_pkg::NARROW_LANES
) (
    input  logic              cfg_dup,
    input  logic [WIDE-1:0]   state,
    input  logic              cs_q,
    output logic [WIDE-1:0]   q_a,
    output logic [NARROW-1:0] q_b,
    output logic              cs_a,
    output logic              cs_b
);
    for (genvar i = 0; i < WIDE; i++) begin : g_out
        if (i < NARROW) begin : g_shared
            // Lanes present in both shapes feed A always and B when duplicated.
            always_comb begin
                q_a[i] = state[i];
                q_b[i] = cfg_dup ? state[i] : 1'b0;
            end
        end else begin : g_wide_only
            // Lanes present only in the wide shape.
            always_comb q_a[i] = cfg_dup ? 1'b0 : state[i];
        end
    end

    // Chip-select copies.
    always_comb begin
        cs_a = cs_q;
        cs_b = cfg_dup ? cs_q : 1'b0;
    end
endmodule

// File: rtl/cmd_regbuf.sv
// Top: configurable registered command buffer (25x1 or 14x2).
// Assumes straps change only under reset; reset is asynchronous active low.
module cmd_regbuf #(
    parameter int WIDE   = cmdreg_pkg::WIDE_LANES,
    parameter int NARROW = cmdreg_pkg::NARROW_LANES,
    parameter int CKE_A  = cmdreg_pkg::CKE_LANE_A,
    parameter int ODT_A  = cmdreg_pkg::ODT_LANE_A,
    parameter int ODT_B  = cmdreg_pkg::ODT_LANE_B,
    parameter int CKE_B  = cmdreg_pkg::CKE_LANE_B
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_dup,
    input  logic              cfg_layout_b,
    input  logic              cs_n,
    input  logic              csr_n,
    input  logic [WIDE-1:0]   d_in,
    output logic [WIDE-1:0]   q_a,
    output logic [NARROW-1:0] q_b,
    output logic              q_cs_n_a,
    output logic              q_cs_n_b
);
    logic [WIDE-1:0] upd_en;
    logic [WIDE-1:0] state;
    logic            cs_q;

    cmdreg_lane_ctrl #(.W(WIDE), .CKE_A(CKE_A), .ODT_A(ODT_A), .ODT_B(ODT_B), .CKE_B(CKE_B)) u_ctrl (
        .cs_n(cs_n), .csr_n(csr_n), .cfg_dup(cfg_dup), .cfg_layout_b(cfg_layout_b), .upd_en(upd_en)
    );

    cmdreg_bank #(.W(WIDE)) u_bank (
        .clk(clk), .rst_n(rst_n), .upd_en(upd_en), .d(d_in), .q(state)
    );

    // Chip-select flop, never gated.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cs_q <= 1'b0;
        else        cs_q <= cs_n;
    end

    cmdreg_fanout #(.WIDE(WIDE), .NARROW(NARROW)) u_fan (
        .cfg_dup(cfg_dup), .state(state), .cs_q(cs_q),
        .q_a(q_a), .q_b(q_b), .cs_a(q_cs_n_a), .cs_b(q_cs_n_b)
    );

    // R1
    reset_low_chk: assert property (@(posedge clk)
        !rst_n |-> (q_a == '0 && q_b == '0 && !q_cs_n_a && !q_cs_n_b));

    // R3
    wide_b_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_dup |-> (q_b == '0 && !q_cs_n_b));

    // R4
    dup_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_dup && !cs_n) |=> (q_b == $past(d_in[NARROW-1:0]) && q_a[NARROW-1:0] == q_b
                                && q_a[WIDE-1:NARROW] == '0));

    // R7
    cs_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> q_cs_n_a == $past(cs_n));

    // R8
    ctrl_a_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && csr_n && !(cfg_dup && cfg_layout_b)) |=>
        (q_a[CKE_A] == $past(d_in[CKE_A]) && q_a[ODT_A] == $past(d_in[ODT_A])));

    // R9
    ctrl_b_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && csr_n && cfg_dup && cfg_layout_b) |=>
        (q_b[CKE_B] == $past(d_in[CKE_B]) && q_b[ODT_B] == $past(d_in[ODT_B])
         && $stable(q_b[CKE_A]) && $stable(q_b[ODT_A])));
endmodule

// File: tb/cmd_regbuf_bench.sv
module cmd_regbuf_bench;
    localparam int W = 25;
    localparam int N = 14;
    localparam int NV = 6;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cfg_dup = 1'b0;
    logic         cfg_layout_b = 1'b0;
    logic         cs_n = 1'b1;
    logic         csr_n = 1'b1;
    logic [W-1:0] d_in = '0;
    logic [W-1:0] q_a;
    logic [N-1:0] q_b;
    logic         q_cs_n_a, q_cs_n_b;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    cmd_regbuf u_cmd_regbuf (
        .clk(clk), .rst_n(rst_n), .cfg_dup(cfg_dup), .cfg_layout_b(cfg_layout_b),
        .cs_n(cs_n), .csr_n(csr_n), .d_in(d_in),
        .q_a(q_a), .q_b(q_b), .q_cs_n_a(q_cs_n_a), .q_cs_n_b(q_cs_n_b)
    );

    // {cs_n, csr_n, d_in, expected q_a, expected q_cs_n_a}, wide mode
    localparam logic [52:0] VEC [NV] = '{
        {1'b0, 1'b1, 25'h1ABCDEF, 25'h1ABCDEF, 1'b0},  // R2 capture
        {1'b1, 1'b1, 25'h0123456, 25'h1ABCDE6, 1'b1},  // R5 R8 gated
        {1'b1, 1'b0, 25'h1555555, 25'h1555555, 1'b1},  // R6 csr_n low only
        {1'b1, 1'b1, 25'h0AAAAAA, 25'h155555C, 1'b1},  // R5 R8 gated
        {1'b1, 1'b1, 25'h1FFFFFF, 25'h155555D, 1'b1},  // R5 R8 gated
        {1'b0, 1'b0, 25'h0000000, 25'h0000000, 1'b0}   // R2 R7
    };

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic apply(input logic c, input logic r, input logic [W-1:0] d);
        @(negedge clk);
        cs_n = c; csr_n = r; d_in = d;
        @(negedge clk);
    endtask

    task automatic restart(input logic dup, input logic lb);
        @(negedge clk);
        rst_n = 1'b0;
        cfg_dup = dup; cfg_layout_b = lb;
        cs_n = 1'b1; csr_n = 1'b1; d_in = '0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 4);
        miscompares++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        // R1 reset state
        repeat (2) @(negedge clk);
        d_in = 25'h1FFFFFF; cs_n = 1'b0;
        chk("R1 q_a in reset", q_a, '0);
        chk("R1 cs in reset", {24'b0, q_cs_n_a}, '0);
        rst_n = 1'b1;
        #1;
        chk("R1 q_a after release before edge", q_a, '0);
        cs_n = 1'b1; d_in = '0;

        // Table walk, wide mode
        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][52], VEC[i][51], VEC[i][50:26]);
            chk($sformatf("R2/R5/R6/R8 vec %0d q_a", i), q_a, VEC[i][25:1]);
            chk($sformatf("R7 vec %0d cs", i), {24'b0, q_cs_n_a}, {24'b0, VEC[i][0]});
            chk($sformatf("R3 vec %0d q_b", i), {11'b0, q_b}, '0);
            chk($sformatf("R3 vec %0d cs_b", i), {24'b0, q_cs_n_b}, '0);
        end

        // Asynchronous reset between edges
        apply(1'b0, 1'b1, 25'h1234567);
        @(negedge clk);
        #0.5 rst_n = 1'b0;
        #0.5;
        chk("R1 async clear", q_a, '0);

        // Duplicated, layout A
        restart(1'b1, 1'b0);
        apply(1'b0, 1'b1, 25'h1FFFFFF);
        chk("R4 q_a dup", q_a, 25'h0003FFF);
        chk("R4 q_b dup", {11'b0, q_b}, 25'h0003FFF);
        chk("R4 cs copies", {24'b0, q_cs_n_b}, {24'b0, q_cs_n_a});
        apply(1'b1, 1'b1, 25'h0000000);
        chk("R8 layout A gated q_b", {11'b0, q_b}, 25'h0003FF6);
        chk("R7 cs dup gated", {23'b0, q_cs_n_a, q_cs_n_b}, 25'h3);

        // Duplicated, layout B
        restart(1'b1, 1'b1);
        apply(1'b0, 1'b0, 25'h1FFFFFF);
        chk("R4 layout B load", {11'b0, q_b}, 25'h0003FFF);
        apply(1'b1, 1'b1, 25'h0000000);
        chk("R9 layout B gated q_b", {11'b0, q_b}, 25'h0001BFF);
        chk("R9 layout B gated q_a", q_a, 25'h0001BFF);
        apply(1'b1, 1'b0, 25'h0000000);
        chk("R6 layout B csr_n low", {11'b0, q_b}, '0);

        finish_run();
    end
endmodule